// File: doc/BRIEF.md
# Four-Lane 7:1 Serializing Link Transmitter

This block accepts a 28-bit parallel word once per pixel-clock period and sends it as four serial data lanes and one forwarded clock lane. A bit clock running at exactly seven times the pixel rate drives all internal state. The pixel clock is oversampled in that domain to find the capture edge, which is either the rising or the falling edge, chosen by a select input. Each captured word is split into four 7-bit slices, one per lane, and each slice is shifted out least significant bit first over seven bit periods.

A captured word waits in a hold register until the next frame boundary, when it moves into the lane shifters. Capture of the following word overlaps the frame that is still shifting out, so frames follow each other with no gap. The forwarded clock lane repeats a fixed 7-bit shape that has a single rising edge per frame. One active-low input acts as both shutdown and clear. While it is low, every register is zero, the clock lane is silent and all lane output enables are off. After it is released, the outputs stay quiet until the first complete word has been captured and loaded.

Top module: `serlink_tx`

## Requirements
- R1: All 28 bits of `data_i` are captured together as one word on the selected pixel-clock edge. Data that is present only away from that edge never reaches the lanes.
- R2: `edge_sel_i` = 0 selects capture on the rising edge of `pix_clk_i`. `edge_sel_i` = 1 selects the falling edge.
- R3: Lane k (`lane_o[k]`) carries bits `data[7k+6:7k]` of a word. Bit `7k+j` is sent in bit period j of the frame, with j = 0 first.
- R4: A frame lasts seven `bit_clk_i` periods. Successive frames carry successive captured words, with no word repeated, skipped or separated by idle periods.
- R5: In every frame, `clk_lane_o` sends the sequence 1,1,0,0,0,1,1 in bit periods 0 to 6. This gives exactly one rising edge per frame.
- R6: While `rst_ni` is low, all lanes, the clock lane and all output enables are 0. This takes effect at once, without waiting for a clock edge.
- R7: After `rst_ni` rises, all lanes, the clock lane and the enables stay 0 until the first fully captured word is loaded. The enables rise together with bit period 0 of that first frame, and that frame carries one of the first words presented after release.
- R8: Once set, `lane_oe_o` stays all ones on all five lanes for as long as `rst_ni` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous shutdown and clear |
| bit_clk_i | input | 1 | Bit clock at seven times the pixel rate |
| pix_clk_i | input | 1 | Pixel clock that marks word capture |
| edge_sel_i | input | 1 | Capture edge: 0 rising, 1 falling |
| data_i | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes, lane k in bit k |
| clk_lane_o | output | 1 | Forwarded clock lane |
| lane_oe_o | output | 5 | Output enables: bits 3..0 for the data lanes, bit 4 for the clock lane |

## Verification
Streams of distinct words are sent with each capture-edge setting, using several seed patterns, including an all-ones mask and an alternating mask. Each word is present only in a window around the selected edge and is replaced by its complement elsewhere. Capturing on the wrong edge therefore produces complemented frames. A wrong lane slice or a wrong bit order breaks the reassembled word, and a dropped or repeated frame breaks the consecutive-index check. Shutdown is applied both before streaming and in the middle of an active stream, and the quiet interval after release is observed sample by sample up to the first frame.

// File: rtl/serlink_pkg.sv
`timescale 1ns/1ps
package serlink_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned SER_DEF   = 7;
  // clock-lane shape, bit 0 sent first: 1,1,0,0,0,1,1
  localparam logic [SER_DEF-1:0] CLK_SHAPE_DEF = 7'b1100011;
endpackage

// File: rtl/serlink_edge_capture.sv
`timescale 1ns/1ps
module serlink_edge_capture #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pix_clk_i,
  input  logic         edge_sel_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o
);
  logic       pix_q1, pix_q2;
  logic [1:0] warm_q;
  logic       cap;

  // warm_q[1] marks that pix_q2 holds a real sample
  assign cap = warm_q[1] & (pix_q1 ^ pix_q2) & (pix_q1 ^ edge_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q1     <= 1'b0;
      pix_q2     <= 1'b0;
      warm_q     <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      pix_q1 <= pix_clk_i;
      pix_q2 <= pix_q1;
      warm_q <= {warm_q[0], 1'b1};
      if (cap) begin
        word_o     <= data_i;
        word_vld_o <= 1'b1;
      end
    end
  end

  p_cap_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> !cap);
  p_word_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(word_o));
endmodule

// File: rtl/serlink_frame_ctrl.sv
`timescale 1ns/1ps
module serlink_frame_ctrl #(
  parameter int unsigned SER = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_vld_i,
  output logic load_o,
  output logic oe_o
);
  localparam int unsigned CNT_W = (SER > 1) ? $clog2(SER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SER - 1);

  logic [CNT_W-1:0] cnt_q;

  assign load_o = (cnt_q == LAST) & word_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_o  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (load_o) oe_o <= 1'b1;
    end
  end

  p_load_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_oe_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |=> oe_o);
  p_oe_after_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(load_o));
endmodule

// File: rtl/serlink_lane_shift.sv
`timescale 1ns/1ps
module serlink_lane_shift #(
  parameter int unsigned SER = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [SER-1:0] par_i,
  output logic           ser_o
);
  logic [SER-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= sh_q >> 1;
  end

  assign ser_o = sh_q[0];

  p_first_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ser_o == $past(par_i[0]));
endmodule

// File: rtl/serlink_tx.sv
`timescale 1ns/1ps
module serlink_tx
  import serlink_pkg::*;
#(
  parameter int unsigned             LANES     = LANES_DEF,
  parameter int unsigned             SER       = SER_DEF,
  parameter logic [SER_DEF-1:0]      CLK_SHAPE = CLK_SHAPE_DEF,
  localparam int unsigned            W         = LANES * SER
) (
  input  logic           rst_ni,
  input  logic           bit_clk_i,
  input  logic           pix_clk_i,
  input  logic           edge_sel_i,
  input  logic [W-1:0]   data_i,
  output logic [LANES-1:0] lane_o,
  output logic           clk_lane_o,
  output logic [LANES:0] lane_oe_o
);
  logic [W-1:0] word;
  logic         word_vld;
  logic         load;
  logic         oe;

  serlink_edge_capture #(.W(W)) u_cap (
    .clk_i      (bit_clk_i),
    .rst_ni     (rst_ni),
    .pix_clk_i  (pix_clk_i),
    .edge_sel_i (edge_sel_i),
    .data_i     (data_i),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  serlink_frame_ctrl #(.SER(SER)) u_frame (
    .clk_i      (bit_clk_i),
    .rst_ni     (rst_ni),
    .word_vld_i (word_vld),
    .load_o     (load),
    .oe_o       (oe)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    serlink_lane_shift #(.SER(SER)) u_lane (
      .clk_i  (bit_clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .par_i  (word[k*SER +: SER]),
      .ser_o  (lane_o[k])
    );
  end

  serlink_lane_shift #(.SER(SER)) u_clk_lane (
    .clk_i  (bit_clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .par_i  (CLK_SHAPE[SER-1:0]),
    .ser_o  (clk_lane_o)
  );

  assign lane_oe_o = {(LANES + 1){oe}};

  p_quiet_off_r7: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !oe |-> (lane_o == '0 && !clk_lane_o));
  p_shut_r6: assert property (@(negedge bit_clk_i)
    !rst_ni |-> (lane_oe_o == '0 && lane_o == '0 && !clk_lane_o));
endmodule

// File: tb/serlink_tx_tb.sv
`timescale 1ns/1ps
module serlink_tx_tb;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0;
  logic        pclk = 1'b0;
  logic        edge_sel = 1'b0;
  logic [27:0] data = '0;
  logic [3:0]  lane_o;
  logic        clk_lane_o;
  logic [4:0]  lane_oe_o;
  int checks = 0;
  int errors = 0;

  serlink_tx u_dut (
    .rst_ni     (rst_ni),
    .bit_clk_i  (bclk),
    .pix_clk_i  (pclk),
    .edge_sel_i (edge_sel),
    .data_i     (data),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o),
    .lane_oe_o  (lane_oe_o)
  );

  always #2 bclk = ~bclk;                    // 250 MHz
  initial begin #1; forever #14 pclk = ~pclk; end

  function automatic logic [27:0] wgen(int i, logic [27:0] seed);
    return 28'(i * 32'h9E3779B1) ^ seed;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    int bad = 0;
    rst_ni = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge bclk);
      if (lane_o != 0 || clk_lane_o || lane_oe_o != 0) bad++;
    end
    check(bad == 0, "R6 reset quiet", bad, 0);
  endtask

  task automatic t_stream(input logic sel, input logic [27:0] seed);
    string tag;
    tag = sel ? "R2 falling" : "R2 rising";
    rst_ni = 1'b0;
    edge_sel = sel;
    data = wgen(0, seed);
    repeat (10) @(posedge bclk);
    #1 rst_ni = 1'b1;
    fork
      begin : drv
        for (int i = 0; i < 40; i++) begin
          if (sel) @(negedge pclk); else @(posedge pclk);
          #10 data = ~wgen(i, seed);
          #12 data = wgen(i + 1, seed);
        end
      end
      begin : rcv
        int n = 0, bad = 0, idx = -1;
        logic [27:0] w;
        logic [6:0] cb;
        int oebad;
        @(negedge bclk);
        while (lane_oe_o == 0 && n < 300) begin
          if (lane_o != 0 || clk_lane_o) bad++;
          n++;
          @(negedge bclk);
        end
        check(bad == 0 && n < 300, "R7 quiet before first frame", n, 0);
        for (int f = 0; f < 12; f++) begin
          w = '0; cb = '0; oebad = 0;
          for (int b = 0; b < 7; b++) begin
            if (!(f == 0 && b == 0)) @(negedge bclk);
            if (lane_oe_o != 5'h1F) oebad++;
            for (int k = 0; k < 4; k++) w[7*k + b] = lane_o[k];
            cb[b] = clk_lane_o;
          end
          if (f == 0) begin
            for (int i = 0; i < 41; i++)
              if (idx < 0 && w == wgen(i, seed)) idx = i;
            check(idx >= 0 && idx <= 3, "R7 first frame word", w, wgen(0, seed));
          end else begin
            check(w == wgen(idx + f, seed), {"R4/R3/R1 frame word ", tag}, w,
                  wgen(idx + f, seed));
          end
          check(cb == 7'b1100011, "R5 clock lane shape", cb, 7'b1100011);
          check(oebad == 0, "R8 enables held", oebad, 0);
        end
      end
    join
  endtask

  task automatic t_shutdown_mid();
    int bad = 0;
    @(posedge bclk);
    #1 rst_ni = 1'b0;
    #0.5;
    check(lane_oe_o == 0 && lane_o == 0 && !clk_lane_o, "R6 async shutdown",
          {lane_oe_o, lane_o, clk_lane_o}, 0);
    for (int i = 0; i < 14; i++) begin
      @(negedge bclk);
      if (lane_o != 0 || clk_lane_o || lane_oe_o != 0) bad++;
    end
    check(bad == 0, "R6 held quiet in shutdown", bad, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_stream(1'b0, 28'h0000000);
    t_shutdown_mid();
    t_stream(1'b1, 28'h5A5A5A5);
    t_stream(1'b0, 28'hFFFFFFF);
    t_stream(1'b1, 28'h0F0F0F0);
    t_shutdown_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule